// File: doc/BRIEF.md
# Multi-Mode 16-Bit Counter with Pulse Generator

This block is a 16-bit counter peripheral with four modes. It can act as an interval timer, an edge counter or a gated window counter. It can also measure the width of pulses on an input pin, or generate a programmable pulse waveform on an output pin. Software drives it through a small byte-wide write port: one 8-bit control register and two 16-bit limit registers, A and B. Each limit register is written as a low byte and a high byte.

The limit registers are double-buffered. A new value is staged first and reaches the counter logic only on a later tick of the source clock. The counter runs on a one-cycle `tick` strobe, which comes from an external prescaler. The `pin_in` input is synchronised inside the block and then serves as the trigger, the gate, the event source or the measured signal, depending on the mode. The block raises `irq` for one cycle on a limit match or on a capture. Register contents are visible on read-back ports.

Write addresses: 0 is control, 1 and 2 are the low and high bytes of A, 3 and 4 are the low and high bytes of B.

Control register bits:
- [1:0] run field: 00 stop and clear, 01 run now, 10 run from a pin rising edge, 11 run from a pin falling edge.
- [3:2] mode: 00 timer or event counter, 01 window, 10 pulse width, 11 pulse generator.
- [4] auto-capture enable.
- [5] variant bit. In pulse-width mode it selects single-edge capture. In timer mode it makes the trigger edge both start and stop the count. In pulse-generator mode it selects one-shot.
- [6] initial output level.
- [7] count pin rising edges instead of ticks (timer mode only).

Top module: `mtimer16`

## Requirements
- R1: After reset, A and B read 0xFFFF, control reads 0x00, `ppg_out` is 0 and `irq` is 0.
- R2: A limit value written as low byte then high byte takes effect on the first `tick` after the high-byte write. A low-byte write alone never changes the read-back, and without a tick the read-back stays unchanged.
- R3: Writes to B (addresses 3 and 4) are dropped unless the mode is 11. In mode 11 they are accepted.
- R4: With run field 00 the counter is held at 0. With 10, counting waits for a rising pin edge. When bit 5 is set in timer mode, the opposite pin edge stops the count, clears it and re-arms the trigger while the run field keeps its value.
- R5: In timer mode with run field 01, `irq` pulses once every A ticks, and the counter wraps from A-1 to 0.
- R6: With bit 7 set in timer mode, the counter advances on synchronised rising edges of `pin_in` instead of on ticks.
- R7: In window mode the counter advances on ticks only while the synchronised pin is high.
- R8: In pulse-width mode with bit 5 set, the number of ticks during which the pin was high is copied into A at the falling edge, and `irq` pulses once per pulse.
- R9: In pulse-width mode with bit 5 clear, every pin edge copies the tick count since the previous edge into A and pulses `irq`.
- R10: In mode 11 with bit 5 clear, `ppg_out` toggles when the counter reaches B and again when it reaches A, giving a period of A ticks in which the non-initial level lasts A-B ticks. `irq` pulses once per period.
- R11: In mode 11 with bit 5 set, one period is produced. The run field then returns to 00 and `ppg_out` returns to the level in bit 6.
- R12: With bit 4 set, B follows the live counter in modes 00 and 01. In modes 10 and 11, bit 4 leaves B unchanged.
- R13: Bits 7:2 other than bit 4 are written only while the run field is 00. While the counter is running, writes to these bits are ignored.
- R14: While `stop_req` is high, the run field is forced to 00. It stays 00 after `stop_req` falls until software writes it again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Source-clock strobe, one cycle per count step |
| pin_in | input | 1 | Asynchronous trigger, gate, event or measured pin |
| stop_req | input | 1 | Power-down request; forces the run field to 00 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 control, 1/2 A low/high, 3/4 B low/high) |
| wr_data | input | 8 | Write byte |
| ppg_out | output | 1 | Pulse generator output level |
| irq | output | 1 | One-cycle match or capture pulse |
| ctrl_rd | output | 8 | Control register read-back |
| data_a | output | 16 | Active A value (limit, or captured width) |
| data_b | output | 16 | Active B value (limit, or auto-captured count) |

## Verification
The interval function is checked with free-running ticks, measuring the gap between successive `irq` pulses. This separates a counter that wraps at A from one that wraps at A-1 or A+1. Pin-driven modes are fed pulses of known, differing widths: a high pulse of 7 ticks for single-edge capture, and a high phase of 9 followed by a low phase of 6 for double-edge capture. Together these expose an off-by-one at the capture edge and confirm which edges capture. Window and trigger modes are observed through auto-capture into B. This shows that the count holds while the gate is low or the trigger has not yet occurred, and clears on the stopping edge. The pulse generator is checked by counting high cycles over two full periods, which separates correct B and A toggle points from a swapped or shifted pair.

// File: rtl/mtimer16_pkg.sv
package mtimer16_pkg;
  typedef enum logic [1:0] {M_TIMER = 2'b00, M_WINDOW = 2'b01, M_PWIDTH = 2'b10, M_PPG = 2'b11} mode_e;
  typedef enum logic [1:0] {S_STOP = 2'b00, S_CMD = 2'b01, S_RISE = 2'b10, S_FALL = 2'b11} run_e;
  localparam int AW = 3;
  localparam logic [AW-1:0] AD_CTRL = 3'd0;
  localparam logic [AW-1:0] AD_ALO  = 3'd1;
  localparam logic [AW-1:0] AD_AHI  = 3'd2;
  localparam logic [AW-1:0] AD_BLO  = 3'd3;
  localparam logic [AW-1:0] AD_BHI  = 3'd4;
endpackage

// File: rtl/mt_edge.sv
module mt_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], pin};
  end

  assign level = sh_q[STAGES-1];
  assign rise  = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall  = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/mt_dbuf.sv
module mt_dbuf #(
  parameter int             W    = 16,
  parameter logic [W-1:0]   INIT = '1,
  localparam int            HW   = W / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_lo,
  input  logic          we_hi,
  input  logic [HW-1:0] wdata,
  input  logic          tick,
  input  logic          ld,
  input  logic [W-1:0]  ld_val,
  output logic [W-1:0]  val,
  output logic          pend
);
  logic [HW-1:0] lo_q, hi_q;
  logic [W-1:0]  val_q;
  logic          pend_q;
  logic          commit;

  assign commit = tick && pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q   <= INIT[HW-1:0];
      hi_q   <= INIT[W-1:HW];
      pend_q <= 1'b0;
      val_q  <= INIT;
    end else begin
      if (we_lo) lo_q <= wdata;
      if (we_hi) hi_q <= wdata;
      if (we_hi)     pend_q <= 1'b1;
      else if (tick) pend_q <= 1'b0;
      if (ld)          val_q <= ld_val;
      else if (commit) val_q <= {hi_q, lo_q};
    end
  end

  assign val  = val_q;
  assign pend = pend_q;

  // R2: the active value moves only on a tick-aligned commit or a capture load
  a_r2_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !(tick && pend_q)) |=> (val_q == $past(val_q)));
  // R2: a high-byte write arms a pending commit
  a_r2_hi_arms: assert property (@(posedge clk) disable iff (!rst_n)
    we_hi |=> pend_q);
endmodule

// File: rtl/mtimer16.sv
module mtimer16
  import mtimer16_pkg::*;
#(
  parameter int CW   = 16,
  parameter int SYNC = 2,
  localparam int HW  = CW / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          pin_in,
  input  logic          stop_req,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [HW-1:0] wr_data,
  output logic          ppg_out,
  output logic          irq,
  output logic [7:0]    ctrl_rd,
  output logic [CW-1:0] data_a,
  output logic [CW-1:0] data_b
);
  function automatic logic [CW-1:0] f_bump(input logic [CW-1:0] c);
    return c + 1'b1;
  endfunction

  function automatic logic f_reach(input logic [CW-1:0] c, input logic [CW-1:0] lim);
    return f_bump(c) == lim;
  endfunction

  run_e          run_fld_q;
  mode_e         mode_q;
  logic          acap_q, var_q, ffi_q, evt_q;
  logic          run_q, ppg_q, irq_q;
  logic [CW-1:0] cnt_q;

  logic pin_lvl, pin_rise, pin_fall;
  mt_edge #(.STAGES(SYNC)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin(pin_in),
    .level(pin_lvl), .rise(pin_rise), .fall(pin_fall)
  );

  logic wr_ctrl, idle;
  logic is_tmr, is_win, is_pw, is_ppg;
  logic trig_edge, end_edge, ext_stop;
  logic src, gate, cnt_en, cap_evt, hit_a, hit_b, oneshot_done;
  logic ld_b, we_b_ok;
  logic a_pend, b_pend;

  assign wr_ctrl = wr_en && (wr_addr == AD_CTRL);
  assign idle    = (run_fld_q == S_STOP);
  assign is_tmr  = (mode_q == M_TIMER);
  assign is_win  = (mode_q == M_WINDOW);
  assign is_pw   = (mode_q == M_PWIDTH);
  assign is_ppg  = (mode_q == M_PPG);

  assign trig_edge = (run_fld_q == S_RISE) ? pin_rise : pin_fall;
  assign end_edge  = (run_fld_q == S_RISE) ? pin_fall : pin_rise;
  assign ext_stop  = run_q && is_tmr && var_q && run_fld_q[1] && end_edge;

  assign src    = (is_tmr && evt_q) ? pin_rise : tick;
  assign gate   = (is_win || (is_pw && var_q)) ? pin_lvl : 1'b1;
  assign cnt_en = run_q && src && gate;

  assign cap_evt      = run_q && is_pw && (var_q ? pin_fall : (pin_rise || pin_fall));
  assign hit_a        = cnt_en && !is_pw && f_reach(cnt_q, data_a);
  assign hit_b        = cnt_en && is_ppg && f_reach(cnt_q, data_b);
  assign oneshot_done = hit_a && is_ppg && var_q;

  assign ld_b    = acap_q && !mode_q[1];
  assign we_b_ok = wr_en && is_ppg;

  mt_dbuf #(.W(CW), .INIT('1)) u_lim_a (
    .clk(clk), .rst_n(rst_n),
    .we_lo(wr_en && (wr_addr == AD_ALO)), .we_hi(wr_en && (wr_addr == AD_AHI)),
    .wdata(wr_data), .tick(tick), .ld(cap_evt), .ld_val(cnt_q),
    .val(data_a), .pend(a_pend)
  );

  mt_dbuf #(.W(CW), .INIT('1)) u_lim_b (
    .clk(clk), .rst_n(rst_n),
    .we_lo(we_b_ok && (wr_addr == AD_BLO)), .we_hi(we_b_ok && (wr_addr == AD_BHI)),
    .wdata(wr_data), .tick(tick), .ld(ld_b), .ld_val(cnt_q),
    .val(data_b), .pend(b_pend)
  );

  // control register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_fld_q <= S_STOP;
      mode_q    <= M_TIMER;
      acap_q    <= 1'b0;
      var_q     <= 1'b0;
      ffi_q     <= 1'b0;
      evt_q     <= 1'b0;
    end else begin
      if (stop_req)          run_fld_q <= S_STOP;
      else if (wr_ctrl)      run_fld_q <= run_e'(wr_data[1:0]);
      else if (oneshot_done) run_fld_q <= S_STOP;
      if (wr_ctrl) acap_q <= wr_data[4];
      if (wr_ctrl && idle) begin
        mode_q <= mode_e'(wr_data[3:2]);
        var_q  <= wr_data[5];
        ffi_q  <= wr_data[6];
        evt_q  <= wr_data[7];
      end
    end
  end

  // run state, counter, output flip-flop, interrupt
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      ppg_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (idle || oneshot_done || ext_stop) run_q <= 1'b0;
      else if (run_fld_q == S_CMD)          run_q <= 1'b1;
      else if (trig_edge)                   run_q <= 1'b1;

      if (idle || ext_stop) cnt_q <= '0;
      else if (cap_evt)     cnt_q <= cnt_en ? CW'(1) : '0;
      else if (hit_a)       cnt_q <= '0;
      else if (cnt_en)      cnt_q <= f_bump(cnt_q);

      if (idle)                ppg_q <= ffi_q;
      else if (hit_a || hit_b) ppg_q <= ~ppg_q;

      irq_q <= hit_a || cap_evt;
    end
  end

  assign ppg_out = ppg_q;
  assign irq     = irq_q;
  assign ctrl_rd = {evt_q, ffi_q, var_q, acap_q, mode_q, run_fld_q};

  a_r14_stop_forces_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> (run_fld_q == S_STOP));
  a_r13_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (run_fld_q != S_STOP) |=> $stable(mode_q));
  a_r11_oneshot_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (oneshot_done && !stop_req && !wr_ctrl) |=> (run_fld_q == S_STOP));
  a_r12_no_acap_upper_modes: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[1] && !b_pend) |=> $stable(data_b));
  a_r10_toggle_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit_a || hit_b) && !idle) |=> (ppg_q != $past(ppg_q)));
  a_r4_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> (cnt_q == '0));
  a_r8_capture_loads_a: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (data_a == $past(cnt_q)));
  a_r2_a_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_pend && !cap_evt) |=> $stable(data_a));
endmodule

// File: tb/sim_mtimer16.sv
module sim_mtimer16;
  localparam int PER = 10;

  logic clk = 0, rst_n = 0, tick = 1, pin_in = 0, stop_req = 0, wr_en = 0;
  logic [2:0]  wr_addr = 0;
  logic [7:0]  wr_data = 0;
  logic        ppg_out, irq;
  logic [7:0]  ctrl_rd;
  logic [15:0] data_a, data_b;

  mtimer16 u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pin_in(pin_in), .stop_req(stop_req),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ppg_out(ppg_out), .irq(irq), .ctrl_rd(ctrl_rd), .data_a(data_a), .data_b(data_b)
  );

  always #(PER/2) clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0, irq_total = 0;
  int sb_epoch = 0, mon_epoch = 0, last_irq = 0;
  int exp_q[$];
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: measures gaps between irq pulses and pops expected gaps
  always @(negedge clk) begin
    if (rst_n && irq) begin
      irq_total++;
      if (mon_epoch != sb_epoch) begin
        mon_epoch = sb_epoch;
      end else if (exp_q.size() > 0) begin
        int e;
        e = exp_q.pop_front();
        check(cyc - last_irq == e, "R5/R10 irq period", cyc - last_irq, e);
      end
      last_irq = cyc;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic idle_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_gaps(input int p, input int n);
    sb_epoch++;
    for (int i = 0; i < n; i++) exp_q.push_back(p);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  initial begin
    #(PER * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    int hi_cnt, base;
    idle_n(3);
    rst_n = 1;
    @(negedge clk);
    // R1
    check(data_a == 16'hFFFF, "R1 A reset", data_a, 16'hFFFF);
    check(data_b == 16'hFFFF, "R1 B reset", data_b, 16'hFFFF);
    check(ctrl_rd == 8'h00, "R1 ctrl reset", ctrl_rd, 0);
    check(ppg_out == 1'b0, "R1 ppg reset", ppg_out, 0);
    check(irq == 1'b0, "R1 irq reset", irq, 0);

    // R2: byte-split commit on tick
    tick = 0;
    wr(3'd1, 8'd5); idle_n(3);
    check(data_a == 16'hFFFF, "R2 low byte alone", data_a, 16'hFFFF);
    wr(3'd2, 8'd0); idle_n(3);
    check(data_a == 16'hFFFF, "R2 no tick yet", data_a, 16'hFFFF);
    tick = 1; @(negedge clk); tick = 0;
    check(data_a == 16'd5, "R2 commit on tick", data_a, 5);
    tick = 1;

    // R3: B write ignored outside mode 11
    wr(3'd3, 8'd2); wr(3'd4, 8'd0); idle_n(3);
    check(data_b == 16'hFFFF, "R3 B write dropped", data_b, 16'hFFFF);

    // R5: timer period A=5
    expect_gaps(5, 3);
    wr(3'd0, 8'h01);
    drain();
    // R13: mode write while running ignored
    wr(3'd0, 8'h0D);
    check(ctrl_rd[3:2] == 2'b00, "R13 mode locked", ctrl_rd[3:2], 0);
    wr(3'd0, 8'h00); idle_n(3);

    // R14: stop request
    wr(3'd0, 8'h01); idle_n(4);
    @(negedge clk) stop_req = 1;
    @(negedge clk) stop_req = 0;
    idle_n(2);
    check(ctrl_rd[1:0] == 2'b00, "R14 run field cleared", ctrl_rd[1:0], 0);

    // R4 + R12: trigger start/stop observed via auto-capture
    wr(3'd1, 8'd100); wr(3'd2, 8'd0); idle_n(2);
    wr(3'd0, 8'h32); idle_n(5);
    check(data_b == 16'd0, "R4 armed, not counting", data_b, 0);
    pin_in = 1; idle_n(10);
    check(data_b > 0 && data_b < 16'd100, "R4/R12 counting after rise", data_b, 8);
    pin_in = 0; idle_n(6);
    check(data_b == 16'd0, "R4 opposite edge clears", data_b, 0);
    check(ctrl_rd[1:0] == 2'b10, "R4 run field kept", ctrl_rd[1:0], 2);
    wr(3'd0, 8'h00); idle_n(2);

    // R6: event counting
    wr(3'd0, 8'h91); idle_n(3);
    for (int i = 0; i < 3; i++) begin
      pin_in = 1; idle_n(3); pin_in = 0; idle_n(3);
    end
    idle_n(4);
    check(data_b == 16'd3, "R6 pin events counted", data_b, 3);
    wr(3'd0, 8'h00); idle_n(2);

    // R7: window
    wr(3'd0, 8'h15); idle_n(5);
    check(data_b == 16'd0, "R7 no count while low", data_b, 0);
    pin_in = 1; idle_n(10); pin_in = 0; idle_n(6);
    check(data_b == 16'd10, "R7 count while high", data_b, 10);
    wr(3'd0, 8'h00); idle_n(2);

    // R8: single-edge pulse width
    wr(3'd0, 8'h29); idle_n(4);
    base = irq_total;
    pin_in = 1; idle_n(7); pin_in = 0; idle_n(5);
    check(data_a == 16'd7, "R8 captured width", data_a, 7);
    check(irq_total - base == 1, "R8 one irq", irq_total - base, 1);
    wr(3'd0, 8'h00); idle_n(2);

    // R9: double-edge
    wr(3'd0, 8'h09); idle_n(4);
    base = irq_total;
    pin_in = 1; idle_n(9); pin_in = 0; idle_n(4);
    check(data_a == 16'd9, "R9 high phase", data_a, 9);
    idle_n(2); pin_in = 1; idle_n(5);
    check(data_a == 16'd6, "R9 low phase", data_a, 6);
    check(irq_total - base == 3, "R9 irq per edge", irq_total - base, 3);
    wr(3'd0, 8'h00); pin_in = 0; idle_n(6);

    // R10: continuous pulse generation A=8 B=3
    wr(3'd0, 8'h0C);
    wr(3'd3, 8'd3); wr(3'd4, 8'd0);
    wr(3'd1, 8'd8); wr(3'd2, 8'd0); idle_n(2);
    check(data_b == 16'd3, "R3 B accepted in mode 11", data_b, 3);
    check(ppg_out == 1'b0, "R10 idle level", ppg_out, 0);
    expect_gaps(8, 3);
    wr(3'd0, 8'h1D);
    drain();
    hi_cnt = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (ppg_out) hi_cnt++;
    end
    check(hi_cnt == 10, "R10 high cycles in two periods", hi_cnt, 10);
    check(data_b == 16'd3, "R12 acap ignored in mode 11", data_b, 3);
    wr(3'd0, 8'h0C); idle_n(2);
    check(ppg_out == 1'b0, "R10 back to idle level", ppg_out, 0);

    // R11: one-shot with initial level 1
    wr(3'd0, 8'h6C); idle_n(2);
    check(ppg_out == 1'b1, "R11 initial level", ppg_out, 1);
    base = irq_total;
    wr(3'd0, 8'h6D); idle_n(30);
    check(irq_total - base == 1, "R11 single period", irq_total - base, 1);
    check(ctrl_rd[1:0] == 2'b00, "R11 run field returns to 00", ctrl_rd[1:0], 0);
    check(ppg_out == 1'b1, "R11 output back to initial", ppg_out, 1);

    finish_run();
  end
endmodule